// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block sits beside a DRAM command controller and makes sure that refresh happens often enough. An interval timer, counted in clock cycles, sets the spacing of refresh commands. The designer derives the interval from the retention period divided by the number of rows. For example, 64 ms spread over 8K rows gives one refresh about every 7.8 us, and 4K rows give one about every 15.6 us. When the timer expires, the block raises a refresh request. It waits until the controller reports that every bank is idle and grants the command slot. It then emits a one-cycle auto-refresh command strobe.

After each command the block holds a busy flag for the refresh cycle time, also in cycles. The controller must send no other command while the flag is high. No precharge is needed afterwards, because the device leaves every bank precharged.

The block keeps the refresh row counter, which steps once per command and wraps after the last row. Intervals that expire while a request is still waiting are not lost. They are counted as postponed refreshes, up to a set limit. The request stays raised until all of them have been served.

Top module: `refresh_sched`

## Requirements
- R1: While reset is high, and on the first cycle after it, the request, the command strobe and the busy flag are 0, and the row output is 0.
- R2: The interval timer reloads on reset and whenever a command is issued. If no command issues, the request rises after the INTERVAL_CYC-th clock edge following reset release.
- R3: A command issues at a clock edge where the request is high, the all-banks-idle input is high, the grant input is high and busy is low. The command strobe is high for exactly the one cycle after that edge.
- R4: No command strobe appears while either the all-banks-idle input or the grant input is low, even with a request pending.
- R5: The busy flag is high for exactly TRFC_CYC cycles, starting with the command cycle. No command issues while it is high, so back-to-back commands are TRFC_CYC+1 cycles apart.
- R6: The row output gives the row refreshed by the current or next command. It starts at 0 and steps by one at the end of each command cycle. After ROWS-1 it wraps to 0.
- R7: Each interval that expires while refreshes are still owed adds one postponed refresh. Every owed refresh later yields exactly one command.
- R8: The number of owed refreshes saturates at MAX_DEBT. Further expiries are dropped.
- R9: The request is high exactly while at least one refresh is owed. It falls in the command cycle of the last owed refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| banks_idle_i | input | 1 | Controller reports all banks idle |
| grant_i | input | 1 | Controller grants the command slot to refresh |
| ref_req_o | output | 1 | At least one refresh is owed |
| ref_cmd_o | output | 1 | One-cycle auto-refresh command strobe |
| busy_o | output | 1 | Refresh cycle time in progress; no other command allowed |
| ref_row_o | output | clog2(ROWS) | Row refreshed by the current or next command |

## Verification
On every cycle the assertions check these properties:
- Every strobe follows a sampled request with idle and grant.
- A strobe lasts one cycle, and busy covers it.
- A busy run never exceeds TRFC_CYC cycles.
- The row only moves after a strobe, by one with wrap-around.

The timing of the first request after reset is shown only by the bench's scenarios, as is the exact TRFC_CYC+1 spacing of back-to-back commands. The same holds for the accumulation and saturation of postponed refreshes and the request falling on the last owed command. The bench shows these by holding the idle flag low across several intervals and then draining the backlog.

// File: rtl/refresh_pkg.sv
package refresh_pkg;
  function automatic int unsigned width_for(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/refi_timer.sv
module refi_timer
  import refresh_pkg::*;
#(
  parameter int unsigned INTERVAL_CYC = 1560
) (
  input  logic clk,
  input  logic rst,
  input  logic reload_i,
  output logic expire_o
);
  localparam int unsigned TW = width_for(INTERVAL_CYC);
  localparam logic [TW-1:0] TOP = TW'(INTERVAL_CYC - 1);

  logic [TW-1:0] cnt_q;

  assign expire_o = (cnt_q == '0) && !reload_i;

  always_ff @(posedge clk) begin
    if (rst)                          cnt_q <= TOP;
    else if (reload_i || cnt_q == '0) cnt_q <= TOP;
    else                              cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/refresh_debt.sv
module refresh_debt
  import refresh_pkg::*;
#(
  parameter int unsigned MAX_DEBT = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic expire_i,
  input  logic issue_i,
  output logic req_o
);
  localparam int unsigned DW = width_for(MAX_DEBT + 1);
  localparam logic [DW-1:0] CAP = DW'(MAX_DEBT);

  logic [DW-1:0] owed_q, owed_d;

  always_comb begin
    owed_d = owed_q;
    if (issue_i && owed_d != '0)     owed_d = owed_d - 1'b1;
    if (expire_i && owed_d != CAP)   owed_d = owed_d + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      owed_q <= '0;
      req_o  <= 1'b0;
    end else begin
      owed_q <= owed_d;
      req_o  <= (owed_d != '0);
    end
  end
endmodule

// File: rtl/trfc_guard.sv
module trfc_guard
  import refresh_pkg::*;
#(
  parameter int unsigned TRFC_CYC = 15
) (
  input  logic clk,
  input  logic rst,
  input  logic issue_i,
  output logic cmd_o,
  output logic busy_o
);
  localparam int unsigned BW = width_for(TRFC_CYC);
  localparam logic [BW-1:0] LAST = BW'(TRFC_CYC - 1);

  logic [BW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_o  <= 1'b0;
      busy_o <= 1'b0;
      left_q <= '0;
    end else begin
      cmd_o <= issue_i;
      if (issue_i) begin
        busy_o <= 1'b1;
        left_q <= LAST;
      end else if (busy_o) begin
        if (left_q != '0) left_q <= left_q - 1'b1;
        else              busy_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/refresh_row_ctr.sv
module refresh_row_ctr
  import refresh_pkg::*;
#(
  parameter int unsigned ROWS = 8192
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       step_i,
  output logic [width_for(ROWS)-1:0] row_o
);
  localparam int unsigned RW = width_for(ROWS);
  localparam logic [RW-1:0] LAST = RW'(ROWS - 1);

  always_ff @(posedge clk) begin
    if (rst)                 row_o <= '0;
    else if (step_i) begin
      if (row_o == LAST)     row_o <= '0;
      else                   row_o <= row_o + 1'b1;
    end
  end
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
  import refresh_pkg::*;
#(
  parameter int unsigned INTERVAL_CYC = 1560,
  parameter int unsigned TRFC_CYC     = 15,
  parameter int unsigned ROWS         = 8192,
  parameter int unsigned MAX_DEBT     = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       banks_idle_i,
  input  logic                       grant_i,
  output logic                       ref_req_o,
  output logic                       ref_cmd_o,
  output logic                       busy_o,
  output logic [width_for(ROWS)-1:0] ref_row_o
);
  logic issue;
  logic expire;

  assign issue = ref_req_o && banks_idle_i && grant_i && !busy_o;

  refi_timer #(.INTERVAL_CYC(INTERVAL_CYC)) u_timer (
    .clk(clk), .rst(rst), .reload_i(issue), .expire_o(expire)
  );

  refresh_debt #(.MAX_DEBT(MAX_DEBT)) u_debt (
    .clk(clk), .rst(rst), .expire_i(expire), .issue_i(issue), .req_o(ref_req_o)
  );

  trfc_guard #(.TRFC_CYC(TRFC_CYC)) u_guard (
    .clk(clk), .rst(rst), .issue_i(issue), .cmd_o(ref_cmd_o), .busy_o(busy_o)
  );

  refresh_row_ctr #(.ROWS(ROWS)) u_row (
    .clk(clk), .rst(rst), .step_i(ref_cmd_o), .row_o(ref_row_o)
  );
endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk
  import refresh_pkg::*;
#(
  parameter int unsigned TRFC_CYC = 15,
  parameter int unsigned ROWS     = 8192
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       banks_idle_i,
  input logic                       grant_i,
  input logic                       ref_req_o,
  input logic                       ref_cmd_o,
  input logic                       busy_o,
  input logic [width_for(ROWS)-1:0] ref_row_o
);
  localparam int unsigned RW = width_for(ROWS);
  localparam logic [RW-1:0] LAST = RW'(ROWS - 1);

  int unsigned busy_run;
  always_ff @(posedge clk) begin
    if (rst || !busy_o) busy_run <= 0;
    else                busy_run <= busy_run + 1;
  end

  p_cmd_cond_r3: assert property (@(posedge clk) disable iff (rst)
    ref_cmd_o |-> $past(ref_req_o && banks_idle_i && grant_i));
  p_cmd_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    ref_cmd_o |=> !ref_cmd_o);
  p_busy_on_cmd_r5: assert property (@(posedge clk) disable iff (rst)
    ref_cmd_o |-> (busy_o && busy_run == 0));
  p_busy_len_r5: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> (busy_run < TRFC_CYC));
  p_row_step_r6: assert property (@(posedge clk) disable iff (rst)
    ref_cmd_o |=> (ref_row_o == (($past(ref_row_o) == LAST) ? '0 : $past(ref_row_o) + 1'b1)));
  p_row_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !ref_cmd_o |=> $stable(ref_row_o));
endmodule

bind refresh_sched refresh_sched_chk #(.TRFC_CYC(TRFC_CYC), .ROWS(ROWS)) u_chk (
  .clk(clk), .rst(rst), .banks_idle_i(banks_idle_i), .grant_i(grant_i),
  .ref_req_o(ref_req_o), .ref_cmd_o(ref_cmd_o), .busy_o(busy_o), .ref_row_o(ref_row_o)
);

// File: tb/refresh_sched_tb.sv
`timescale 1ns/1ps
module refresh_sched_tb_top;
  localparam int INTERVAL = 20;
  localparam int TRFC     = 4;
  localparam int ROWS     = 6;
  localparam int MAXD     = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic idle = 1'b0;
  logic grant = 1'b0;
  logic req, cmd, busy;
  logic [2:0] row;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  refresh_sched #(.INTERVAL_CYC(INTERVAL), .TRFC_CYC(TRFC), .ROWS(ROWS), .MAX_DEBT(MAXD)) dut_i (
    .clk(clk), .rst(rst), .banks_idle_i(idle), .grant_i(grant),
    .ref_req_o(req), .ref_cmd_o(cmd), .busy_o(busy), .ref_row_o(row)
  );

  // behavioural reference model
  int m_tmr, m_owed, m_bleft, m_row, m_ncmd;
  bit m_req, m_cmd, m_busy;
  always @(posedge clk) begin
    if (rst) begin
      m_tmr = INTERVAL - 1; m_owed = 0; m_bleft = 0; m_row = 0;
      m_req = 0; m_cmd = 0; m_busy = 0; m_ncmd = 0;
    end else begin
      bit iss, exp_t;
      iss   = m_req && idle && grant && !m_busy;
      exp_t = !iss && (m_tmr == 0);
      m_tmr = (iss || m_tmr == 0) ? INTERVAL - 1 : m_tmr - 1;
      if (m_cmd) m_row = (m_row + 1) % ROWS;
      if (iss && m_owed > 0) m_owed--;
      if (exp_t && m_owed < MAXD) m_owed++;
      m_req = (m_owed != 0);
      if (iss) begin m_busy = 1; m_bleft = TRFC - 1; end
      else if (m_busy) begin
        if (m_bleft != 0) m_bleft--; else m_busy = 0;
      end
      m_cmd = iss;
      if (iss) m_ncmd++;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp_v, $time);
    end
  endtask

  always @(negedge clk) if (!rst && !done) begin
    chk(req == m_req,   "R2/R9 req vs model",  req,  m_req);
    chk(cmd == m_cmd,   "R3 cmd vs model",     cmd,  m_cmd);
    chk(busy == m_busy, "R5 busy vs model",    busy, m_busy);
    chk(int'(row) == m_row, "R6 row vs model", row,  m_row);
  end

  task automatic finish_run();
    done = 1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n, first, gap, prev;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(req == 0 && cmd == 0 && busy == 0, "R1 flags in reset", {req, cmd, busy}, 0);
    chk(row == 0, "R1 row in reset", row, 0);
    rst = 0;
    @(negedge clk);
    chk(req == 0 && cmd == 0 && busy == 0 && row == 0, "R1 first cycle", {req, cmd, busy, row}, 0);
    // R2 first request timing (1 edge already seen)
    repeat (INTERVAL - 2) @(negedge clk);
    chk(req == 0, "R2 before interval", req, 0);
    @(negedge clk);
    chk(req == 1, "R2 at interval", req, 1);
    // R4 idle without grant, grant without idle
    idle = 1; grant = 0;
    for (int i = 0; i < 4; i++) begin @(negedge clk); chk(cmd == 0, "R4 no grant", cmd, 0); end
    idle = 0; grant = 1;
    for (int i = 0; i < 4; i++) begin @(negedge clk); chk(cmd == 0, "R4 not idle", cmd, 0); end
    idle = 1;
    @(negedge clk);
    chk(cmd == 1, "R3 strobe", cmd, 1);
    chk(busy == 1, "R5 busy with strobe", busy, 1);
    chk(req == 0, "R9 req falls on last owed", req, 0);
    chk(row == 0, "R6 first row", row, 0);
    @(negedge clk);
    chk(cmd == 0, "R3 single cycle", cmd, 0);
    chk(row == 1, "R6 step", row, 1);
    // R6 wrap: run several intervals with everything granted
    repeat (8 * (INTERVAL + 1)) @(negedge clk);
    chk(m_ncmd > ROWS, "R6 enough commands for wrap", m_ncmd, ROWS + 1);
    chk(int'(row) == (m_ncmd - (cmd ? 1 : 0)) % ROWS, "R6 wrap", row, (m_ncmd - (cmd ? 1 : 0)) % ROWS);
    // R7 postponed refreshes below the cap
    idle = 0;
    repeat (2 * INTERVAL + 5) @(negedge clk);
    first = m_owed;
    chk(first >= 2 && first <= MAXD, "R7 owed accumulated", first, 2);
    idle = 1; n = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (cmd) n++;
      if (!req) begin chk(cmd == 1, "R9 req falls in last cmd cycle", cmd, 1); break; end
    end
    chk(n == first, "R7 one command per owed refresh", n, first);
    // R8 saturation and R5 spacing
    idle = 0;
    repeat (5 * INTERVAL + 5) @(negedge clk);
    chk(req == 1, "R7 req held while owed", req, 1);
    idle = 1; n = 0; prev = -1; gap = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (cmd) begin
        n++;
        if (prev >= 0) chk(i - prev == TRFC + 1, "R5 command spacing", i - prev, TRFC + 1);
        prev = i;
      end
      if (!req) break;
    end
    chk(n == MAXD, "R8 saturated debt", n, MAXD);
    repeat (TRFC + 2) @(negedge clk);
    chk(busy == 0 && req == 0, "R5 quiet after drain", {busy, req}, 0);
    finish_run();
  end
endmodule